// File: doc/BRIEF.md
# Binary32 Floating-Point Adder with Exception Flags

This block adds two IEEE-754 single-precision operands, a destination and a source, and returns the sum as the new destination value. Each operand is classified as zero, normal, denormal, infinity, quiet NaN or signalling NaN. Special operands are resolved from a fixed table. All other pairs go through alignment with guard, round and sticky bits, then addition or subtraction, then normalization. Rounding follows one of four IEEE modes, chosen by a two-bit input.

Each operation also produces an eight-bit exception byte. A second, sticky byte accumulates every flag raised since the last reset. The caller raises `start_i` for one cycle with the operands and the rounding mode. Exactly one clock edge later, `valid_o` is high and the result, the exception byte and the updated sticky byte are on the outputs. A small two-state controller paces this. It has `ST_IDLE` (no result presented) and `ST_RESULT` (a result presented). Its transitions are `accept`, taken from either state when `start_i` is high, and `drain`, from `ST_RESULT` back to `ST_IDLE` when `start_i` is low. Back-to-back requests keep the controller in `ST_RESULT`.

Top module: `fpadd_unit`

## Requirements
- R1: `valid_o` is high in the cycle after the clock edge at which `start_i` was sampled high, and low after any edge at which `start_i` was low or reset was active.
- R2: For finite operands whose sum is representable, `result_o` equals `dst_i + src_i`. This includes cancellation down to a small power of two.
- R3: `rmode_i` encodes 00 round-to-nearest-even, 01 toward zero, 10 toward minus infinity and 11 toward plus infinity. A sum that lies between two representable values is rounded according to that mode.
- R4: Two zeros of equal sign give that zero. An exact zero from operands of opposite sign, including x + (−x), gives −0 (0x80000000) in mode 10 and +0 in the other three modes.
- R5: An infinity plus any finite value or zero returns that infinity with its own sign. Two infinities of equal sign return that infinity.
- R6: Infinities of opposite sign return 0x7FFFFFFF and set the operation-error flag, bit 5. No other operand pair sets bit 5.
- R7: A NaN operand is returned with its quiet bit (bit 22) set. A destination NaN wins over a source NaN. Bit 6 is set when either operand is a signalling NaN (exponent all ones, bit 22 clear, nonzero fraction).
- R8: On overflow, bits 4 (overflow) and 1 (inexact) are set. The result is infinity in mode 00, the largest finite value in mode 01, and in modes 10 and 11 it is infinity only when the sign points toward that infinity.
- R9: Denormal operands are handled exactly. Bit 3 (underflow) is set only when the result is tiny before rounding and also inexact, so exact denormal sums raise no flag.
- R10: Bit 1 (inexact) is set exactly when the returned finite value differs from the exact sum.
- R11: Bits 7 (unordered), 2 (divide-by-zero) and 0 (decimal-input inexact) of the exception byte are always 0.
- R12: With each accepted operation, `accrued_o` becomes its previous value ORed with the new exception byte. It holds when no operation is accepted, and synchronous reset clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Accept operands and rounding mode this cycle |
| dst_i | input | 32 | Destination operand, binary32 |
| src_i | input | 32 | Source operand, binary32 |
| rmode_i | input | 2 | Rounding mode (00 nearest, 01 zero, 10 down, 11 up) |
| valid_o | output | 1 | Result, exception byte and sticky byte are presented |
| result_o | output | 32 | Sum returned as the new destination value |
| exc_o | output | 8 | Exception byte of the latest operation |
| accrued_o | output | 8 | Sticky OR of all exception bytes since reset |

## Verification
Any fault in the operand classification, the alignment shift or the round decision is visible in the first `valid_o` cycle. It shows up as a wrong `result_o` or `exc_o` word one edge after the request. A corrupted sticky byte is only visible on `accrued_o`. It stays wrong for every later operation until reset, so the bench compares it after each request and during idle cycles. A controller stuck in the wrong state shows at once as `valid_o` being high or low one cycle off from `start_i`.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

    parameter int EXP_W  = 8;
    parameter int FRAC_W = 23;

    localparam int WORD_W   = 1 + EXP_W + FRAC_W;
    localparam int SIG_W    = FRAC_W + 1;
    localparam int GRS_W    = 3;
    localparam int EXT_W    = SIG_W + GRS_W;
    localparam int EXPI_W   = EXP_W + 2;
    localparam int EXC_W    = 8;
    localparam int EXP_ONES = (1 << EXP_W) - 1;

    localparam logic [WORD_W-1:0] DEFAULT_NAN = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b1}}};

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_DOWN = 2'b10,
        RM_UP   = 2'b11
    } rmode_e;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_NORM,
        CL_DENORM,
        CL_INF,
        CL_QNAN,
        CL_SNAN
    } fclass_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESULT
    } state_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
        fclass_e           cls;
        logic [EXPI_W-1:0] eff_exp;
        logic [SIG_W-1:0]  sig;
    } opnd_t;

    // Bit order matters: bit 7 down to bit 0.
    typedef struct packed {
        logic unordered;
        logic snan;
        logic operr;
        logic ovfl;
        logic unfl;
        logic divz;
        logic inex;
        logic inex_dec;
    } exc_t;

    function automatic int lead_zeros(input logic [EXT_W-1:0] v);
        int cnt;
        cnt = EXT_W;
        for (int i = 0; i < EXT_W; i++) begin
            if (v[i]) cnt = EXT_W - 1 - i;
        end
        return cnt;
    endfunction

endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack
    import fpadd_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output opnd_t             op_o
);

    logic              sgn;
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;
    logic              ex_zero;
    logic              ex_ones;
    logic              fr_zero;
    fclass_e           cls;

    always_comb begin
        sgn     = word_i[WORD_W-1];
        ex      = word_i[WORD_W-2 -: EXP_W];
        fr      = word_i[FRAC_W-1:0];
        ex_zero = (ex == '0);
        ex_ones = &ex;
        fr_zero = (fr == '0);

        if (ex_ones) begin
            if (fr_zero)            cls = CL_INF;
            else if (fr[FRAC_W-1])  cls = CL_QNAN;
            else                    cls = CL_SNAN;
        end else if (ex_zero) begin
            cls = fr_zero ? CL_ZERO : CL_DENORM;
        end else begin
            cls = CL_NORM;
        end

        op_o.sign    = sgn;
        op_o.exp     = ex;
        op_o.frac    = fr;
        op_o.cls     = cls;
        op_o.eff_exp = ex_zero ? EXPI_W'(1) : EXPI_W'(ex);
        op_o.sig     = {~ex_zero, fr};
    end

endmodule

// File: rtl/fpadd_addnorm.sv
module fpadd_addnorm
    import fpadd_pkg::*;
(
    input  opnd_t             dst_i,
    input  opnd_t             src_i,
    input  rmode_e            rm_i,
    output logic              sign_o,
    output logic [EXPI_W-1:0] exp_o,
    output logic [EXT_W-1:0]  norm_o,
    output logic              zero_o
);

    opnd_t             big;
    opnd_t             sml;
    logic [EXPI_W-1:0] gap;
    logic [EXT_W-1:0]  big_ext;
    logic [EXT_W-1:0]  sml_ext;
    logic [EXT_W-1:0]  sml_sh;
    logic [EXT_W-1:0]  lost_mask;
    logic              sticky;
    logic              subtract;
    logic [EXT_W:0]    sum;
    int                lz;
    int                room;
    int                shamt;

    always_comb begin
        // Larger magnitude operand leads; ties keep the destination first.
        if ({src_i.exp, src_i.frac} > {dst_i.exp, dst_i.frac}) begin
            big = src_i;
            sml = dst_i;
        end else begin
            big = dst_i;
            sml = src_i;
        end

        gap       = big.eff_exp - sml.eff_exp;
        big_ext   = {big.sig, {GRS_W{1'b0}}};
        sml_ext   = {sml.sig, {GRS_W{1'b0}}};
        lost_mask = '0;

        if (gap >= EXPI_W'(EXT_W)) begin
            sml_sh = '0;
            sticky = |sml.sig;
        end else begin
            lost_mask = ~({EXT_W{1'b1}} << gap);
            sml_sh    = sml_ext >> gap;
            sticky    = |(sml_ext & lost_mask);
        end
        sml_sh[0] = sml_sh[0] | sticky;

        subtract = big.sign ^ sml.sign;
        sum = subtract ? ({1'b0, big_ext} - {1'b0, sml_sh})
                       : ({1'b0, big_ext} + {1'b0, sml_sh});

        zero_o = (sum == '0);
        if (zero_o) begin
            sign_o = (dst_i.sign == src_i.sign) ? dst_i.sign : (rm_i == RM_DOWN);
        end else begin
            sign_o = big.sign;
        end

        lz    = 0;
        room  = 0;
        shamt = 0;
        if (sum[EXT_W]) begin
            norm_o    = sum[EXT_W:1];
            norm_o[0] = sum[1] | sum[0];
            exp_o     = big.eff_exp + EXPI_W'(1);
        end else begin
            lz     = lead_zeros(sum[EXT_W-1:0]);
            room   = int'(big.eff_exp) - 1;
            shamt  = (lz < room) ? lz : room;
            norm_o = sum[EXT_W-1:0] << shamt;
            exp_o  = big.eff_exp - EXPI_W'(shamt);
        end
    end

endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
    import fpadd_pkg::*;
(
    input  logic              sign_i,
    input  logic [EXPI_W-1:0] exp_i,
    input  logic [EXT_W-1:0]  norm_i,
    input  rmode_e            rm_i,
    output logic [WORD_W-1:0] word_o,
    output logic              ovfl_o,
    output logic              unfl_o,
    output logic              inex_o
);

    logic [SIG_W-1:0]  mant;
    logic              guard;
    logic              tail;
    logic              lost;
    logic              bump;
    logic              to_max;
    logic [SIG_W:0]    rounded;
    logic [EXPI_W-1:0] exp_r;
    logic [FRAC_W-1:0] frac_r;

    always_comb begin
        mant  = norm_i[EXT_W-1:GRS_W];
        guard = norm_i[GRS_W-1];
        tail  = |norm_i[GRS_W-2:0];
        lost  = guard | tail;

        unique case (rm_i)
            RM_NEAR: bump = guard & (tail | mant[0]);
            RM_ZERO: bump = 1'b0;
            RM_DOWN: bump = lost & sign_i;
            RM_UP:   bump = lost & ~sign_i;
            default: bump = 1'b0;
        endcase

        rounded = {1'b0, mant} + (SIG_W+1)'(bump);
        if (rounded[SIG_W]) begin
            exp_r  = exp_i + EXPI_W'(1);
            frac_r = '0;
        end else begin
            exp_r  = rounded[SIG_W-1] ? exp_i : '0;
            frac_r = rounded[FRAC_W-1:0];
        end

        ovfl_o = (exp_r >= EXPI_W'(EXP_ONES));
        unfl_o = ~norm_i[EXT_W-1] & lost;
        inex_o = lost | ovfl_o;

        to_max = (rm_i == RM_ZERO) ||
                 ((rm_i == RM_DOWN) && !sign_i) ||
                 ((rm_i == RM_UP) && sign_i);

        if (ovfl_o) begin
            if (to_max) word_o = {sign_i, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
            else        word_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else begin
            word_o = {sign_i, exp_r[EXP_W-1:0], frac_r};
        end
    end

endmodule

// File: rtl/fpadd_unit.sv
module fpadd_unit
    import fpadd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WORD_W-1:0] dst_i,
    input  logic [WORD_W-1:0] src_i,
    input  logic [1:0]        rmode_i,
    output logic              valid_o,
    output logic [WORD_W-1:0] result_o,
    output logic [EXC_W-1:0]  exc_o,
    output logic [EXC_W-1:0]  accrued_o
);

    state_e            state;
    state_e            state_nxt;
    rmode_e            rm;
    opnd_t             op_d;
    opnd_t             op_s;
    logic              ar_sign;
    logic [EXPI_W-1:0] ar_exp;
    logic [EXT_W-1:0]  ar_norm;
    logic              ar_zero;
    logic [WORD_W-1:0] rnd_word;
    logic              rnd_ovfl;
    logic              rnd_unfl;
    logic              rnd_inex;
    logic [WORD_W-1:0] nxt_res;
    exc_t              nxt_flags;
    logic              d_nan;
    logic              s_nan;
    logic [WORD_W-1:0] quiet_bit;
    logic [WORD_W-1:0] result_q;
    logic [EXC_W-1:0]  exc_q;
    logic [EXC_W-1:0]  acc_q;

    assign rm        = rmode_e'(rmode_i);
    assign quiet_bit = WORD_W'(1) << (FRAC_W - 1);

    fpadd_unpack u_unpack_dst (.word_i(dst_i), .op_o(op_d));
    fpadd_unpack u_unpack_src (.word_i(src_i), .op_o(op_s));

    fpadd_addnorm u_addnorm (
        .dst_i  (op_d),
        .src_i  (op_s),
        .rm_i   (rm),
        .sign_o (ar_sign),
        .exp_o  (ar_exp),
        .norm_o (ar_norm),
        .zero_o (ar_zero)
    );

    fpadd_round u_round (
        .sign_i (ar_sign),
        .exp_i  (ar_exp),
        .norm_i (ar_norm),
        .rm_i   (rm),
        .word_o (rnd_word),
        .ovfl_o (rnd_ovfl),
        .unfl_o (rnd_unfl),
        .inex_o (rnd_inex)
    );

    // Special-value selection ahead of the arithmetic result.
    always_comb begin
        d_nan     = (op_d.cls == CL_QNAN) || (op_d.cls == CL_SNAN);
        s_nan     = (op_s.cls == CL_QNAN) || (op_s.cls == CL_SNAN);
        nxt_flags = '0;
        nxt_res   = rnd_word;

        if (d_nan || s_nan) begin
            nxt_res        = d_nan ? (dst_i | quiet_bit) : (src_i | quiet_bit);
            nxt_flags.snan = (op_d.cls == CL_SNAN) || (op_s.cls == CL_SNAN);
        end else if ((op_d.cls == CL_INF) && (op_s.cls == CL_INF) &&
                     (op_d.sign != op_s.sign)) begin
            nxt_res         = DEFAULT_NAN;
            nxt_flags.operr = 1'b1;
        end else if (op_d.cls == CL_INF) begin
            nxt_res = dst_i;
        end else if (op_s.cls == CL_INF) begin
            nxt_res = src_i;
        end else if (ar_zero) begin
            nxt_res = {ar_sign, {(WORD_W-1){1'b0}}};
        end else begin
            nxt_res        = rnd_word;
            nxt_flags.ovfl = rnd_ovfl;
            nxt_flags.unfl = rnd_unfl;
            nxt_flags.inex = rnd_inex;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (start_i) state_nxt = ST_RESULT;
            ST_RESULT: state_nxt = start_i ? ST_RESULT : ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // Result capture on accept.
    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            exc_q    <= '0;
            acc_q    <= '0;
        end else if (start_i) begin
            result_q <= nxt_res;
            exc_q    <= nxt_flags;
            acc_q    <= acc_q | nxt_flags;
        end
    end

    // Outputs.
    always_comb begin
        valid_o   = (state == ST_RESULT);
        result_o  = result_q;
        exc_o     = exc_q;
        accrued_o = acc_q;
    end

endmodule

// File: rtl/fpadd_chk.sv
module fpadd_chk
    import fpadd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              valid_o,
    input logic [WORD_W-1:0] result_o,
    input logic [EXC_W-1:0]  exc_o,
    input logic [EXC_W-1:0]  accrued_o
);

    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        start_i |=> valid_o);

    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !valid_o);

    p_fixed_clear_r11: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (exc_o[7] == 1'b0 && exc_o[2] == 1'b0 && exc_o[0] == 1'b0));

    p_operr_nan_r6: assert property (@(posedge clk) disable iff (rst)
        (valid_o && exc_o[5]) |-> (result_o == DEFAULT_NAN));

    p_snan_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (valid_o && exc_o[6]) |-> ((&result_o[WORD_W-2 -: EXP_W]) && result_o[FRAC_W-1]));

    p_ovfl_inex_r8: assert property (@(posedge clk) disable iff (rst)
        (valid_o && exc_o[4]) |-> exc_o[1]);

    p_unfl_inex_r9: assert property (@(posedge clk) disable iff (rst)
        (valid_o && exc_o[3]) |-> exc_o[1]);

    p_acc_cover_r12: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ((accrued_o & exc_o) == exc_o));

    p_acc_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> $stable(accrued_o));

endmodule

bind fpadd_unit fpadd_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .valid_o   (valid_o),
    .result_o  (result_o),
    .exc_o     (exc_o),
    .accrued_o (accrued_o)
);

// File: tb/tb_fpadd_unit.sv
module tb_fpadd_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] dst;
    logic [31:0] src;
    logic [1:0]  rm;
    logic        valid;
    logic [31:0] res;
    logic [7:0]  exc;
    logic [7:0]  acc;

    int          checks    = 0;
    int          failures  = 0;
    logic [7:0]  acc_model = 8'h00;
    bit          finished  = 1'b0;

    always #2 clk = ~clk;

    fpadd_unit dut (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .dst_i     (dst),
        .src_i     (src),
        .rmode_i   (rm),
        .valid_o   (valid),
        .result_o  (res),
        .exc_o     (exc),
        .accrued_o (acc)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
        end
    endtask

    task automatic run_add(input logic [31:0] d, input logic [31:0] s,
                           input logic [1:0] m, input logic [31:0] er,
                           input logic [7:0] ee, input string tag);
        @(negedge clk);
        dst = d; src = s; rm = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        acc_model = acc_model | ee;
        check(valid === 1'b1, {tag, " valid R1"}, 32'(valid), 32'd1);
        check(res === er, {tag, " result"}, res, er);
        check(exc === ee, {tag, " flags R11"}, 32'(exc), 32'(ee));
        check(acc === acc_model, {tag, " accrued R12"}, 32'(acc), 32'(acc_model));
    endtask

    task automatic t_reset_state;
        check(valid === 1'b0, "R1 reset valid", 32'(valid), 32'd0);
        check(acc === 8'h00, "R12 reset accrued", 32'(acc), 32'd0);
        check(exc === 8'h00, "R11 reset flags", 32'(exc), 32'd0);
    endtask

    task automatic t_exact_sums;
        run_add(32'h3F800000, 32'h40000000, 2'b00, 32'h40400000, 8'h00, "R2 1+2");
        run_add(32'h3FC00000, 32'h3FC00000, 2'b01, 32'h40400000, 8'h00, "R2 1.5+1.5");
        run_add(32'h3F800001, 32'hBF800000, 2'b00, 32'h34000000, 8'h00, "R2 cancel");
    endtask

    task automatic t_rounding;
        run_add(32'h3F800000, 32'h33800000, 2'b00, 32'h3F800000, 8'h02, "R3 R10 tie-even");
        run_add(32'h3F800000, 32'h33C00000, 2'b00, 32'h3F800001, 8'h02, "R3 above-half");
        run_add(32'h3F800000, 32'h33800000, 2'b11, 32'h3F800001, 8'h02, "R3 up");
        run_add(32'h3F800000, 32'h33800000, 2'b01, 32'h3F800000, 8'h02, "R3 zero");
        run_add(32'hBF800000, 32'hB3800000, 2'b10, 32'hBF800001, 8'h02, "R3 down neg");
        run_add(32'hBF800000, 32'hB3800000, 2'b11, 32'hBF800000, 8'h02, "R3 up neg");
        run_add(32'h3F800000, 32'hB3000000, 2'b00, 32'h3F800000, 8'h02, "R3 R10 sub tie");
        run_add(32'h3F800000, 32'hB3000000, 2'b01, 32'h3F7FFFFF, 8'h02, "R3 sub trunc");
    endtask

    task automatic t_zero_sign;
        run_add(32'h00000000, 32'h80000000, 2'b00, 32'h00000000, 8'h00, "R4 +0-0 near");
        run_add(32'h00000000, 32'h80000000, 2'b10, 32'h80000000, 8'h00, "R4 +0-0 down");
        run_add(32'h80000000, 32'h80000000, 2'b11, 32'h80000000, 8'h00, "R4 -0-0 up");
        run_add(32'h3F800000, 32'hBF800000, 2'b10, 32'h80000000, 8'h00, "R4 x-x down");
        run_add(32'h3F800000, 32'hBF800000, 2'b11, 32'h00000000, 8'h00, "R4 x-x up");
    endtask

    task automatic t_infinity;
        run_add(32'h7F800000, 32'h3F800000, 2'b00, 32'h7F800000, 8'h00, "R5 inf+1");
        run_add(32'h80000000, 32'hFF800000, 2'b10, 32'hFF800000, 8'h00, "R5 -0+-inf");
        run_add(32'hFF800000, 32'hFF800000, 2'b00, 32'hFF800000, 8'h00, "R5 -inf-inf");
        run_add(32'h7F800000, 32'hFF800000, 2'b00, 32'h7FFFFFFF, 8'h20, "R6 inf-inf");
    endtask

    task automatic t_nan;
        run_add(32'h7FC00001, 32'h7F800001, 2'b00, 32'h7FC00001, 8'h40, "R7 dst priority");
        run_add(32'h3F800000, 32'h7F800005, 2'b00, 32'h7FC00005, 8'h40, "R7 src snan");
        run_add(32'h7FC00000, 32'h3F800000, 2'b00, 32'h7FC00000, 8'h00, "R7 dst qnan");
        check((exc & 8'h85) === 8'h00, "R11 fixed bits", 32'(exc), 32'd0);
    endtask

    task automatic t_overflow;
        run_add(32'h7F7FFFFF, 32'h7F7FFFFF, 2'b00, 32'h7F800000, 8'h12, "R8 near");
        run_add(32'h7F7FFFFF, 32'h7F7FFFFF, 2'b01, 32'h7F7FFFFF, 8'h12, "R8 zero");
        run_add(32'hFF7FFFFF, 32'hFF7FFFFF, 2'b11, 32'hFF7FFFFF, 8'h12, "R8 up neg");
        run_add(32'hFF7FFFFF, 32'hFF7FFFFF, 2'b10, 32'hFF800000, 8'h12, "R8 down neg");
        run_add(32'h7F7FFFFF, 32'h73000000, 2'b00, 32'h7F800000, 8'h12, "R8 round carry");
    endtask

    task automatic t_denormal;
        run_add(32'h00000001, 32'h00000001, 2'b00, 32'h00000002, 8'h00, "R9 tiny sum");
        run_add(32'h00400000, 32'h00400000, 2'b00, 32'h00800000, 8'h00, "R9 to normal");
        run_add(32'h00800001, 32'h80800000, 2'b00, 32'h00000001, 8'h00, "R9 to denormal");
    endtask

    task automatic t_idle_hold;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(valid === 1'b0, "R1 idle valid", 32'(valid), 32'd0);
            check(acc === acc_model, "R12 idle hold", 32'(acc), 32'(acc_model));
        end
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        dst = 32'h3F800000; src = 32'h40000000; rm = 2'b00; start = 1'b1;
        @(negedge clk);
        check(res === 32'h40400000, "R1 first of pair", res, 32'h40400000);
        dst = 32'h40000000; src = 32'h40000000;
        @(negedge clk);
        start = 1'b0;
        check(valid === 1'b1, "R1 pair valid", 32'(valid), 32'd1);
        check(res === 32'h40800000, "R2 second of pair", res, 32'h40800000);
    endtask

    task automatic t_mid_reset;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        acc_model = 8'h00;
        check(acc === 8'h00, "R12 reset clears", 32'(acc), 32'd0);
        check(valid === 1'b0, "R1 reset valid", 32'(valid), 32'd0);
        run_add(32'h7F800000, 32'hFF800000, 2'b00, 32'h7FFFFFFF, 8'h20, "R12 after reset");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; dst = '0; src = '0; rm = 2'b00;
        repeat (3) @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        t_exact_sums();
        t_rounding();
        t_zero_sign();
        t_infinity();
        t_nan();
        t_overflow();
        t_denormal();
        t_idle_hold();
        t_back_to_back();
        t_mid_reset();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule